// File: doc/BRIEF.md
# Root Port Inbound Request Filter

This block decides, for each inbound request arriving at a PCI Express style root port, whether the request may proceed. Software programs it through a small register port. The registers hold a two-bit device power state, a hold-off switch, an enable for a bus-number range check, and the lower and upper bus-number bounds of the port's downstream hierarchy.

Each request is offered as a descriptor for one cycle. The descriptor carries a request kind, a target bus number, and a posted or non-posted flag. On the next clock edge the block registers a verdict. The verdict is one of four codes: accept, block, unsupported request, or malformed. A separate fatal flag marks the malformed case.

The verdict follows a fixed priority. Hold-off is applied first, then the power-state gate, then the bus-range check. A request that passes all three is accepted.

Top module: `rpf_filter`

## Requirements
- R1: After reset the register reads are: address 0 (power state, bits 1:0) gives 0, address 1 (bit 0 hold-off, bit 1 range-check enable) gives 0, address 2 (bits 7:0 lower bound, bits 15:8 upper bound) gives 0. `vrd_valid` is low.
- R2: A write of 2'b00 (full power) or 2'b11 (low power) to address 0 is stored. A write of 2'b01 or 2'b10 leaves the stored power state unchanged.
- R3: In low power, configuration Type 0 requests (kind 2) are accepted. Memory requests (kind 0) and I/O requests (kind 1) get verdict code 2'b01 (block).
- R4: In low power, configuration Type 1 requests (kind 3) get code 2'b01.
- R5: While hold-off is set, every request kind gets code 2'b01, whatever the power state or the range settings.
- R6: With the range check enabled, a memory request is in range when lower <= bus <= upper, with both bounds inclusive and compared as unsigned 8-bit values. An in-range memory request is accepted.
- R7: With the range check enabled, an out-of-range posted memory request (a write) gets code 2'b10 with fatal low. An out-of-range non-posted memory request (a read) gets code 2'b11 with fatal high.
- R8: I/O, configuration (kinds 2 and 3), message (kind 4) and completion (kind 5) requests are never range-checked. In full power without hold-off they are accepted for any bus number.
- R9: A request that the power state blocks gets code 2'b01 even when it is also out of range.
- R10: `vrd_valid` is high exactly in the cycle after a cycle with `req_valid` high. Code 2'b00 means accept.
- R11: With the range check disabled, memory requests in full power are accepted for any bus number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational from cfg_addr) |
| req_valid | input | 1 | Request descriptor strobe |
| req_type | input | 3 | Request kind: 0 mem, 1 I/O, 2 cfg0, 3 cfg1, 4 msg, 5 cpl |
| req_posted | input | 1 | 1 = posted (write), 0 = non-posted |
| req_bus | input | 8 | Target bus number |
| vrd_valid | output | 1 | Verdict valid |
| vrd_code | output | 2 | 00 accept, 01 block, 10 unsupported, 11 malformed |
| vrd_fatal | output | 1 | Fatal error flag |

## Verification
The assertions assume that `req_type` carries one of the six defined kinds while `req_valid` is high. They also assume that register writes and requests never share a cycle, so each verdict is judged against settled register contents. The bench keeps within these assumptions. It writes the registers in their own cycles, lets them settle, and only then offers a single request. It never drives the two undefined kind codes.

// File: rtl/rpf_pkg.sv
// Shared types for the root port request filter.
// Assumes an 8-bit bus number and a 16-bit register data path.
package rpf_pkg;

    typedef enum logic [2:0] {
        RQ_MEM  = 3'd0,
        RQ_IO   = 3'd1,
        RQ_CFG0 = 3'd2,
        RQ_CFG1 = 3'd3,
        RQ_MSG  = 3'd4,
        RQ_CPL  = 3'd5
    } rq_kind_e;

    typedef enum logic [1:0] {
        VD_ACCEPT = 2'b00,
        VD_BLOCK  = 2'b01,
        VD_UNSUP  = 2'b10,
        VD_MALF   = 2'b11
    } verdict_e;

    localparam logic [1:0] PS_FULL = 2'b00;
    localparam logic [1:0] PS_LOW  = 2'b11;

    localparam logic [1:0] ADDR_PS    = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_BOUND = 2'd2;

endpackage

// File: rtl/rpf_cfg_regs.sv
// Register file for the filter: power state, control bits and bus bounds.
// A write of an illegal power-state encoding is dropped.
// Read data is combinational from the address.
// Assumes DATA_W >= 2*BUS_W.
module rpf_cfg_regs
    import rpf_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        ps_o,
    output logic              hold_o,
    output logic              chk_o,
    output logic [BUS_W-1:0]  lo_o,
    output logic [BUS_W-1:0]  hi_o
);
    localparam int PAD_PS   = DATA_W - 2;
    localparam int PAD_BND  = DATA_W - 2*BUS_W;

    logic [1:0]       ps_q;
    logic             hold_q;
    logic             chk_q;
    logic [BUS_W-1:0] lo_q;
    logic [BUS_W-1:0] hi_q;
    logic             ps_legal;

    // Decide whether the incoming power-state value is an accepted encoding.
    always_comb begin
        ps_legal = (wdata[1:0] == PS_FULL) || (wdata[1:0] == PS_LOW);
    end

    // Hold the power-state field; illegal encodings are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= PS_FULL;
        end else if (we && addr == ADDR_PS && ps_legal) begin
            ps_q <= wdata[1:0];
        end
    end

    // Hold the hold-off and range-check enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            chk_q  <= 1'b0;
        end else if (we && addr == ADDR_CTRL) begin
            hold_q <= wdata[0];
            chk_q  <= wdata[1];
        end
    end

    // Hold the lower and upper bus-number bounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (we && addr == ADDR_BOUND) begin
            lo_q <= wdata[BUS_W-1:0];
            hi_q <= wdata[2*BUS_W-1:BUS_W];
        end
    end

    // Multiplex the read-back word.
    always_comb begin
        unique case (addr)
            ADDR_PS:    rdata = {{PAD_PS{1'b0}}, ps_q};
            ADDR_CTRL:  rdata = {{PAD_PS{1'b0}}, chk_q, hold_q};
            ADDR_BOUND: rdata = {{PAD_BND{1'b0}}, hi_q, lo_q};
            default:    rdata = '0;
        endcase
    end

    assign ps_o   = ps_q;
    assign hold_o = hold_q;
    assign chk_o  = chk_q;
    assign lo_o   = lo_q;
    assign hi_o   = hi_q;

    AST_PS_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q == PS_FULL) || (ps_q == PS_LOW)); // R2

    AST_PS_IGNORE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_PS && (wdata[1:0] == 2'b01 || wdata[1:0] == 2'b10))
        |=> $stable(ps_q)); // R2

endmodule

// File: rtl/rpf_classify.sv
// Combinational verdict for one request descriptor.
// Priority: hold-off, then power-state gate, then bus-range check, then accept.
// Only memory requests are range checked.
module rpf_classify
    import rpf_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [1:0]       ps,
    input  logic             hold,
    input  logic             chk,
    input  logic [BUS_W-1:0] lo,
    input  logic [BUS_W-1:0] hi,
    input  logic [2:0]       kind,
    input  logic             posted,
    input  logic [BUS_W-1:0] bus,
    output logic [1:0]       code,
    output logic             fatal
);
    logic     low_power;
    logic     gated_kind;
    logic     in_range;
    logic     range_err;
    verdict_e vd;

    // Work out the power gate and the range test.
    always_comb begin
        low_power  = (ps == PS_LOW);
        gated_kind = (kind == RQ_MEM) || (kind == RQ_IO) || (kind == RQ_CFG1);
        in_range   = (bus >= lo) && (bus <= hi);
        range_err  = chk && (kind == RQ_MEM) && !in_range;
    end

    // Apply the verdict priority.
    always_comb begin
        fatal = 1'b0;
        if (hold) begin
            vd = VD_BLOCK;
        end else if (low_power && gated_kind) begin
            vd = VD_BLOCK;
        end else if (range_err && posted) begin
            vd = VD_UNSUP;
        end else if (range_err) begin
            vd    = VD_MALF;
            fatal = 1'b1;
        end else begin
            vd = VD_ACCEPT;
        end
        code = vd;
    end

endmodule

// File: rtl/rpf_filter.sv
// Top of the root port inbound request filter.
// Registers are written through cfg_*. Each request offered on req_* gets a
// registered verdict one cycle later. Assumes writes and requests are not
// issued in the same cycle when the verdict must reflect the new settings.
module rpf_filter
    import rpf_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic              req_posted,
    input  logic [BUS_W-1:0]  req_bus,
    output logic              vrd_valid,
    output logic [1:0]        vrd_code,
    output logic              vrd_fatal
);
    logic [1:0]       ps;
    logic             hold;
    logic             chk;
    logic [BUS_W-1:0] lo;
    logic [BUS_W-1:0] hi;
    logic [1:0]       nxt_code;
    logic             nxt_fatal;
    logic             valid_q;
    logic [1:0]       code_q;
    logic             fatal_q;

    rpf_cfg_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .ps_o   (ps),
        .hold_o (hold),
        .chk_o  (chk),
        .lo_o   (lo),
        .hi_o   (hi)
    );

    rpf_classify #(.BUS_W(BUS_W)) u_cls (
        .ps     (ps),
        .hold   (hold),
        .chk    (chk),
        .lo     (lo),
        .hi     (hi),
        .kind   (req_type),
        .posted (req_posted),
        .bus    (req_bus),
        .code   (nxt_code),
        .fatal  (nxt_fatal)
    );

    // Register the valid strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= req_valid;
    end

    // Capture the verdict when a request is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= VD_ACCEPT;
            fatal_q <= 1'b0;
        end else if (req_valid) begin
            code_q  <= nxt_code;
            fatal_q <= nxt_fatal;
        end
    end

    assign vrd_valid = valid_q;
    assign vrd_code  = code_q;
    assign vrd_fatal = fatal_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> vrd_valid); // R10

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !vrd_valid); // R10

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hold && !cfg_we) |=> (vrd_code == VD_BLOCK && !vrd_fatal)); // R5

    AST_LOW_CFG1_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we && ps == PS_LOW && req_type == RQ_CFG1)
        |=> (vrd_code == VD_BLOCK)); // R4

    AST_NONMEM_NO_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we && req_type != RQ_MEM)
        |=> (vrd_code != VD_UNSUP && vrd_code != VD_MALF)); // R8

    AST_READ_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we && !hold && ps == PS_FULL && chk && req_type == RQ_MEM
         && !req_posted && req_bus < lo)
        |=> (vrd_code == VD_MALF && vrd_fatal)); // R7

    AST_FATAL_ONLY_MALF: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_fatal |-> (vrd_code == VD_MALF)); // R7

endmodule

// File: tb/rpf_filter_test.sv
module rpf_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_type = 3'd0;
    logic        req_posted = 1'b0;
    logic [7:0]  req_bus = 8'd0;
    logic        vrd_valid;
    logic [1:0]  vrd_code;
    logic        vrd_fatal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpf_filter uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_type(req_type), .req_posted(req_posted), .req_bus(req_bus),
        .vrd_valid(vrd_valid), .vrd_code(vrd_code), .vrd_fatal(vrd_fatal)
    );

    typedef struct packed {
        logic [1:0] ps;
        logic       hold;
        logic       chk;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [2:0] kind;
        logic       posted;
        logic [7:0] bus;
        logic [1:0] code;
        logic       fatal;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'b00,1'b0,1'b0,8'd0,  8'd0,  3'd0,1'b1,8'd5,  2'b00,1'b0,4'd11}, // R11
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd0,1'b1,8'd4,  2'b00,1'b0,4'd6},  // R6 low edge
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd0,1'b0,8'd8,  2'b00,1'b0,4'd6},  // R6 high edge
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd0,1'b1,8'd3,  2'b10,1'b0,4'd7},  // R7 write below
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd0,1'b0,8'd9,  2'b11,1'b1,4'd7},  // R7 read above
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd1,1'b0,8'd200,2'b00,1'b0,4'd8},  // R8 io
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd3,1'b0,8'd200,2'b00,1'b0,4'd8},  // R8 cfg1
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd2,1'b0,8'd0,  2'b00,1'b0,4'd8},  // R8 cfg0
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd4,1'b1,8'd0,  2'b00,1'b0,4'd8},  // R8 msg
        '{2'b00,1'b0,1'b1,8'd4,  8'd8,  3'd5,1'b1,8'd255,2'b00,1'b0,4'd8},  // R8 cpl
        '{2'b11,1'b0,1'b0,8'd0,  8'd0,  3'd2,1'b0,8'd7,  2'b00,1'b0,4'd3},  // R3 cfg0 ok
        '{2'b11,1'b0,1'b0,8'd0,  8'd0,  3'd0,1'b1,8'd0,  2'b01,1'b0,4'd3},  // R3 mem
        '{2'b11,1'b0,1'b0,8'd0,  8'd0,  3'd1,1'b0,8'd0,  2'b01,1'b0,4'd3},  // R3 io
        '{2'b11,1'b0,1'b0,8'd0,  8'd0,  3'd3,1'b0,8'd0,  2'b01,1'b0,4'd4},  // R4
        '{2'b11,1'b0,1'b1,8'd4,  8'd8,  3'd0,1'b0,8'd9,  2'b01,1'b0,4'd9},  // R9
        '{2'b00,1'b1,1'b0,8'd0,  8'd0,  3'd2,1'b0,8'd0,  2'b01,1'b0,4'd5},  // R5 cfg0
        '{2'b00,1'b1,1'b0,8'd0,  8'd0,  3'd4,1'b1,8'd0,  2'b01,1'b0,4'd5},  // R5 msg
        '{2'b11,1'b1,1'b1,8'd4,  8'd8,  3'd0,1'b0,8'd9,  2'b01,1'b0,4'd5},  // R5 over all
        '{2'b00,1'b0,1'b0,8'd4,  8'd8,  3'd0,1'b0,8'd9,  2'b00,1'b0,4'd11}, // R11 read out
        '{2'b00,1'b0,1'b1,8'd100,8'd200,3'd0,1'b0,8'd150,2'b00,1'b0,4'd6},  // R6 mid
        '{2'b00,1'b0,1'b1,8'd100,8'd200,3'd0,1'b0,8'd250,2'b11,1'b1,4'd7},  // R7 high unsigned
        '{2'b00,1'b0,1'b1,8'h80, 8'hF0, 3'd0,1'b1,8'h10, 2'b10,1'b0,4'd6}   // R6 unsigned
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic send(input logic [2:0] k, input logic p, input logic [7:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_type = k; req_posted = p; req_bus = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 valid", {31'd0, vrd_valid}, 32'd0);
        rd(2'd0, d); check("R1 ps", {16'd0, d}, 32'd0);
        rd(2'd1, d); check("R1 ctrl", {16'd0, d}, 32'd0);
        rd(2'd2, d); check("R1 bounds", {16'd0, d}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {14'd0, VEC[i].ps});
            wr(2'd1, {14'd0, VEC[i].chk, VEC[i].hold});
            wr(2'd2, {VEC[i].hi, VEC[i].lo});
            send(VEC[i].kind, VEC[i].posted, VEC[i].bus);
            check($sformatf("R%0d vec%0d valid", VEC[i].req, i), {31'd0, vrd_valid}, 32'd1);
            check($sformatf("R%0d vec%0d code", VEC[i].req, i), {30'd0, vrd_code}, {30'd0, VEC[i].code});
            check($sformatf("R%0d vec%0d fatal", VEC[i].req, i), {31'd0, vrd_fatal}, {31'd0, VEC[i].fatal});
        end

        // R10 valid drops when no request follows
        @(negedge clk);
        check("R10 idle", {31'd0, vrd_valid}, 32'd0);

        // R2 power-state encodings
        wr(2'd1, 16'd0);
        wr(2'd0, 16'd3);
        rd(2'd0, d); check("R2 low stored", {16'd0, d}, 32'd3);
        wr(2'd0, 16'd1);
        rd(2'd0, d); check("R2 01 ignored", {16'd0, d}, 32'd3);
        wr(2'd0, 16'd0);
        rd(2'd0, d); check("R2 full stored", {16'd0, d}, 32'd0);
        wr(2'd0, 16'd2);
        rd(2'd0, d); check("R2 10 ignored", {16'd0, d}, 32'd0);
        send(3'd0, 1'b1, 8'd0);
        check("R2 mem after 10", {30'd0, vrd_code}, 32'd0);

        // R1 reset again clears programmed state
        wr(2'd1, 16'd3);
        wr(2'd2, 16'h0904);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd1, d); check("R1 ctrl after reset", {16'd0, d}, 32'd0);
        rd(2'd2, d); check("R1 bounds after reset", {16'd0, d}, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule